// File: doc/BRIEF.md
# Glitch-Free Multi-Ratio Clock Divider with Rate Halving

This block takes a single fast clock and derives a set of slower clock waveforms from it. One output is a fixed feedback clock at one eighth of the fast rate, so the fast clock can stand in for an oscillator locked at eight times a reference. Each further output runs at a ratio picked by its own 2-bit select code.

A half-rate input doubles the divisor of every selectable output. Each output can also be stopped on its own. Every output is driven straight from a flop.

All control inputs pass through two-flop synchronizers. Ratio and half-rate changes are held back until the end of a common frame. That frame is a whole number of periods of every output, including the slowest one. Stop requests are taken only at the end of the affected output's own period. No output ever shows a shortened high or low phase. The feedback divider is never gated and never changes rate.

Top module: `clkdiv_pwrdn`

## Requirements
- R1: While `rst` is high, `fb_out` and all of `div_out` are low. Reset leaves every select at code 0, half-rate off, every output enabled, and every counter at the start of its period.
- R2: `fb_out` has a period of 8 fast cycles: high for 4 cycles, then low for 4. It ignores `half_rate`, `rate_sel` and `stop_mask`.
- R3: The select code for output i is `rate_sel[2i+1:2i]`. Code 00 divides the fast clock by 2, 01 by 4, 10 by 8 and 11 by 12. Each period is high for its first half and low for its second half.
- R4: While the applied half-rate setting is 1, every selectable output's divisor is twice its R3 value (4, 8, 16 or 24).
- R5: Select and half-rate inputs pass through two synchronizer flops. They are sampled only in the last cycle of a 48-cycle frame and take effect from the first cycle of the next frame. Within a frame the applied ratios never change.
- R6: A 1 on `stop_mask[i]` holds `div_out[i]` low. Stop and restart are taken only at the end of that output's current period. A stopped output therefore never loses part of a high phase, and it restarts with a full high phase.
- R7: Stopping one output leaves the other outputs and `fb_out` unchanged. Half-rate and stop may be active together.
- R8: All counters start together after reset and restart at each frame. Every output's period begins on the first cycle of each frame, so all running outputs rise together there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast source clock; every divider runs on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| half_rate | input | 1 | 1 doubles every selectable output divisor |
| rate_sel | input | 2*N_OUT | 2-bit ratio code per output, output i in bits [2i+1:2i] |
| stop_mask | input | N_OUT | 1 stops the matching output, holding it low |
| fb_out | output | 1 | Feedback clock at one eighth of the fast clock |
| div_out | output | N_OUT | Divided clock outputs |

## Verification
Each output flop reflects the counter state from the cycle before it. The first value after reset therefore appears one edge after `rst` falls. A new select or half-rate value is first visible in the frame that begins after the two synchronizer stages and the frame-end sampling cycle. A stop change is first visible at the first period start that follows the synchronizer delay plus one cycle. The bench runs a cycle-accurate model of these latencies from the requirements and pushes one expected output vector per rising edge into a queue. A monitor pops each vector and compares it on the following falling edge. Because of this, input changes can fall at any phase, including right next to frame ends and period ends.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

  localparam int SEL_W = 2;

  // base divisor for each 2-bit ratio code
  function automatic int base_div(input logic [SEL_W-1:0] code);
    case (code)
      2'd0:    return 2;
      2'd1:    return 4;
      2'd2:    return 8;
      default: return 12;
    endcase
  endfunction

  function automatic int gcd(input int a, input int b);
    int x;
    int y;
    int t;
    x = a;
    y = b;
    while (y != 0) begin
      t = x % y;
      x = y;
      y = t;
    end
    return x;
  endfunction

  // frame = least common multiple of every reachable divisor (doubled ones included)
  function automatic int frame_len();
    int l;
    l = 1;
    for (int c = 0; c < 4; c++) begin
      l = (l * base_div(SEL_W'(c))) / gcd(l, base_div(SEL_W'(c)));
    end
    return 2 * l;
  endfunction

endpackage

// File: rtl/cd_sync.sv
module cd_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/cd_fbdiv.sv
module cd_fbdiv #(
  parameter int FB_DIV = 8
) (
  input  logic clk,
  input  logic rst,
  output logic fb
);
  localparam int FW   = (FB_DIV > 2) ? $clog2(FB_DIV) : 1;
  localparam int HALF = FB_DIV / 2;

  logic [FW-1:0] fbc_q;
  logic          fb_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      fbc_q <= '0;
      fb_q  <= 1'b0;
    end else begin
      fbc_q <= (fbc_q == FW'(FB_DIV - 1)) ? '0 : fbc_q + 1'b1;
      fb_q  <= (fbc_q < FW'(HALF));
    end
  end

  assign fb = fb_q;

  // R2: feedback rises only as a new period begins
  p_fb_rise_start_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(fb_q) |-> (fbc_q == FW'(1)));
endmodule

// File: rtl/cd_frame.sv
module cd_frame
  import clkdiv_pkg::*;
#(
  parameter int N_OUT = 4,
  parameter int CW    = 6,
  parameter int FRAME = 48
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [SEL_W*N_OUT-1:0]   sel_s,
  input  logic                     half_s,
  output logic                     frame_end,
  output logic [N_OUT-1:0][CW-1:0] div_o
);
  localparam int FRW = $clog2(FRAME);

  logic [FRW-1:0]           fr_q;
  logic [SEL_W*N_OUT-1:0]   sel_q;
  logic                     half_q;

  assign frame_end = (fr_q == FRW'(FRAME - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      fr_q   <= '0;
      sel_q  <= '0;
      half_q <= 1'b0;
    end else begin
      fr_q <= frame_end ? '0 : fr_q + 1'b1;
      if (frame_end) begin
        sel_q  <= sel_s;
        half_q <= half_s;
      end
    end
  end

  for (genvar g = 0; g < N_OUT; g++) begin : g_div
    assign div_o[g] = half_q ? CW'(2 * base_div(sel_q[SEL_W*g +: SEL_W]))
                             : CW'(base_div(sel_q[SEL_W*g +: SEL_W]));
  end

  // R5: applied configuration may only change as a new frame begins
  p_cfg_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (fr_q != '0) |-> ($stable(sel_q) && $stable(half_q)));
endmodule

// File: rtl/cd_chan.sv
module cd_chan #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          frame_end,
  input  logic [CW-1:0] div,
  input  logic          stop,
  output logic          out
);
  logic [CW-1:0] cnt_q;
  logic          en_q;
  logic          out_q;
  logic          last;
  logic [CW-1:0] half;

  assign half = div >> 1;
  assign last = (cnt_q == div - CW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      en_q  <= 1'b1;
      out_q <= 1'b0;
    end else begin
      if (frame_end || last) cnt_q <= '0;
      else                   cnt_q <= cnt_q + 1'b1;
      if (last) en_q <= ~stop;
      out_q <= en_q & (cnt_q < half);
    end
  end

  assign out = out_q;

  // R8: every channel period closes exactly at the frame end
  p_frame_align_r8: assert property (@(posedge clk) disable iff (rst)
    frame_end |-> last);

  // R6: gating changes only at the close of a period
  p_gate_edge_r6: assert property (@(posedge clk) disable iff (rst)
    !$stable(en_q) |-> $past(cnt_q == div - CW'(1)));

  // R6: a high phase only ever begins at a period start
  p_rise_start_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(out_q) |-> (cnt_q == CW'(1)));
endmodule

// File: rtl/clkdiv_pwrdn.sv
module clkdiv_pwrdn
  import clkdiv_pkg::*;
#(
  parameter int N_OUT  = 4,
  parameter int FB_DIV = 8
) (
  input  logic                   clk_fast,
  input  logic                   rst,
  input  logic                   half_rate,
  input  logic [2*N_OUT-1:0]     rate_sel,
  input  logic [N_OUT-1:0]       stop_mask,
  output logic                   fb_out,
  output logic [N_OUT-1:0]       div_out
);
  localparam int FRAME = frame_len();
  localparam int CW    = $clog2(FRAME);

  logic [2*N_OUT-1:0]     sel_s;
  logic                   half_s;
  logic [N_OUT-1:0]       stop_s;
  logic                   frame_end;
  logic [N_OUT-1:0][CW-1:0] div_w;

  cd_sync #(.W(2*N_OUT)) u_sync_sel (
    .clk(clk_fast), .rst(rst), .d(rate_sel), .q(sel_s));
  cd_sync #(.W(1)) u_sync_half (
    .clk(clk_fast), .rst(rst), .d(half_rate), .q(half_s));
  cd_sync #(.W(N_OUT)) u_sync_stop (
    .clk(clk_fast), .rst(rst), .d(stop_mask), .q(stop_s));

  cd_frame #(.N_OUT(N_OUT), .CW(CW), .FRAME(FRAME)) u_frame (
    .clk(clk_fast), .rst(rst), .sel_s(sel_s), .half_s(half_s),
    .frame_end(frame_end), .div_o(div_w));

  for (genvar g = 0; g < N_OUT; g++) begin : g_chan
    cd_chan #(.CW(CW)) u_chan (
      .clk(clk_fast), .rst(rst), .frame_end(frame_end),
      .div(div_w[g]), .stop(stop_s[g]), .out(div_out[g]));
  end

  cd_fbdiv #(.FB_DIV(FB_DIV)) u_fb (
    .clk(clk_fast), .rst(rst), .fb(fb_out));
endmodule

// File: tb/test_clkdiv_pwrdn.sv
module test_clkdiv_pwrdn;
  localparam int N     = 4;
  localparam int FRAME = 48;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           half_rate = 1'b0;
  logic [2*N-1:0] rate_sel = '0;
  logic [N-1:0]   stop_mask = '0;
  logic           fb_out;
  logic [N-1:0]   div_out;

  always #4 clk = ~clk;

  clkdiv_pwrdn #(.N_OUT(N), .FB_DIV(8)) i_clkdiv_pwrdn (
    .clk_fast(clk), .rst(rst), .half_rate(half_rate), .rate_sel(rate_sel),
    .stop_mask(stop_mask), .fb_out(fb_out), .div_out(div_out));

  int    checks = 0;
  int    errors = 0;
  string tag = "R1 reset";
  logic [N:0] expq[$];

  // reference model state, built from the requirements
  int m_fr, m_fb;
  int m_cnt[N];
  int m_div[N];
  bit m_en[N];
  logic [2*N-1:0] s1_sel, s2_sel;
  logic s1_half, s2_half;
  logic [N-1:0] s1_stop, s2_stop;
  logic [N:0] e_vec;
  logic [N:0] got;

  function automatic int bdiv(input logic [1:0] c);
    case (c)
      2'd0: return 2;
      2'd1: return 4;
      2'd2: return 8;
      default: return 12;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_fr = 0; m_fb = 0;
      for (int i = 0; i < N; i++) begin
        m_cnt[i] = 0; m_div[i] = 2; m_en[i] = 1'b1;
      end
      s1_sel = '0; s2_sel = '0; s1_half = 0; s2_half = 0;
      s1_stop = '0; s2_stop = '0;
      expq.delete();
    end else begin
      e_vec[N] = (m_fb < 4);
      for (int i = 0; i < N; i++)
        e_vec[i] = m_en[i] && (m_cnt[i] < m_div[i] / 2);
      expq.push_back(e_vec);
      for (int i = 0; i < N; i++) begin
        if (m_cnt[i] == m_div[i] - 1) m_en[i] = !s2_stop[i];
        if (m_fr == FRAME - 1 || m_cnt[i] == m_div[i] - 1) m_cnt[i] = 0;
        else m_cnt[i] = m_cnt[i] + 1;
      end
      if (m_fr == FRAME - 1) begin
        for (int i = 0; i < N; i++)
          m_div[i] = s2_half ? 2 * bdiv(s2_sel[2*i +: 2]) : bdiv(s2_sel[2*i +: 2]);
        m_fr = 0;
      end else begin
        m_fr = m_fr + 1;
      end
      m_fb = (m_fb + 1) % 8;
      s2_sel = s1_sel; s2_half = s1_half; s2_stop = s1_stop;
      s1_sel = rate_sel; s1_half = half_rate; s1_stop = stop_mask;
    end
  end

  // monitor: compare one queued vector per cycle, away from the active edge
  always @(negedge clk) begin
    if (!rst && expq.size() > 0) begin
      got = {fb_out, div_out};
      e_vec = expq.pop_front();
      checks++;
      if (got !== e_vec) begin
        errors++;
        if (errors < 20)
          $display("FAIL %s: {fb,div} actual %b expected %b", tag, got, e_vec);
      end
    end
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic report();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    report();
  end

  initial begin
    run(4);
    // R1: outputs low during reset
    checks++;
    if ({fb_out, div_out} !== '0) begin
      errors++;
      $display("FAIL R1: reset outputs actual %b expected 0", {fb_out, div_out});
    end
    rst = 1'b0;
    tag = "R3 R8 base ratios";
    rate_sel = {2'b11, 2'b10, 2'b01, 2'b00};
    run(130);
    tag = "R4 R5 half rate mid-frame";
    run(17);
    half_rate = 1'b1;
    run(140);
    tag = "R5 select swap while halved";
    rate_sel = {2'b00, 2'b01, 2'b10, 2'b11};
    run(45);
    rate_sel = {2'b01, 2'b11, 2'b00, 2'b10};
    run(120);
    tag = "R6 R7 stop subset with half rate";
    stop_mask = 4'b0101;
    run(7);
    stop_mask = 4'b0111;
    run(110);
    tag = "R6 restart full high phase";
    stop_mask = '0;
    half_rate = 1'b0;
    run(130);
    tag = "R2 R7 all stopped, feedback runs";
    stop_mask = '1;
    run(120);
    // R6: every selectable output held low; R2: feedback still toggling
    checks++;
    if (div_out !== '0) begin
      errors++;
      $display("FAIL R6: stopped outputs actual %b expected 0", div_out);
    end
    tag = "R2 R6 one-cycle stop pulse";
    stop_mask = '0;
    run(9);
    stop_mask = 4'b1000;
    run(1);
    stop_mask = '0;
    run(100);
    report();
  end
endmodule